// File: doc/BRIEF.md
# Wide-to-Narrow Register Access Converter

This block sits between a processor-side register port of CPU_W bits and a narrow control-register bus of CSR_W bits. CPU_W must be a power-of-two multiple of CSR_W. Each processor access becomes a fixed burst of CPU_W/CSR_W narrow accesses. The burst length stays the same even when the target register is narrower than CPU_W. The narrow registers behind the bus take a snapshot when their lowest chunk is read, and they apply the staged value only when their highest chunk is written. For this reason the converter always walks the chunks from the lowest address to the highest, one strobe per cycle, with no gaps.

On the processor side, a request line is held high until a one-cycle acknowledge comes back. The word address, the direction and the write data are captured when the request is accepted. Each narrow address is the captured word address with a chunk index below it. Read chunks are gathered into a full-width word, lowest chunk in the lowest bits, which the processor takes while the acknowledge is high.

Top module: `csr_width_bridge`

## Requirements
- R1: After reset, and while no request has been accepted, both narrow strobes, the acknowledge and the busy flag are low.
- R2: Each accepted request produces exactly CPU_W/CSR_W narrow strobes in consecutive cycles. The first strobe comes in the cycle after acceptance. For chunk i the narrow address is {word address, i}, where i is the low log2(CPU_W/CSR_W) bits, and i rises from 0 to the last chunk.
- R3: During the write strobe of chunk i, the narrow write data equals bits [i*CSR_W +: CSR_W] of the captured write data.
- R4: The narrow data returned in the cycle after the read strobe of chunk i appears in bits [i*CSR_W +: CSR_W] of the read result. A register with a changing value therefore returns the value it held when its lowest chunk was read. Unused chunks of a narrow register read as zero.
- R5: A target register keeps its old value during all chunk writes. It takes the new value only after the write to its last chunk.
- R6: No strobe lasts longer than one cycle per chunk, and the read and write strobes are never high together. Read requests raise only the read strobe, and write requests raise only the write strobe.
- R7: The acknowledge is a single-cycle pulse in the cycle after the last chunk strobe. For reads, the read result is valid during that cycle. In the following cycle no strobe and no acknowledge is active.
- R8: Busy is high from the cycle after acceptance through the acknowledge cycle. Changes to the address or write data while busy have no effect on the narrow accesses in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, held until acknowledge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | WADDR_W | Processor word address |
| cpu_wdata | input | CPU_W | Processor write data |
| cpu_rdata | output | CPU_W | Assembled read result, valid with acknowledge |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Conversion in progress |
| csr_addr | output | WADDR_W+log2(CPU_W/CSR_W) | Narrow bus address |
| csr_rd | output | 1 | Narrow read strobe |
| csr_wr | output | 1 | Narrow write strobe |
| csr_wdata | output | CSR_W | Narrow write data |
| csr_rdata | input | CSR_W | Narrow read data, valid the cycle after a read strobe, else zero |

## Verification
The bench runs a behavioural chunked register file. It contains a free-running counter whose every byte changes each cycle, a 24-bit register and a plain 32-bit register. Reading the counter separates a true snapshot from a chunk-by-chunk read, and only an ascending burst that starts at chunk 0 returns the captured value. Writing the 24-bit register shows whether the commit waits for the fourth strobe and whether the unused top chunk reads back as zero. A write whose address and data are scrambled after acceptance shows whether the request fields were captured. A read from an unmapped word shows that the idle-zero narrow data passes through to the result.

// File: rtl/csrdc_pkg.sv
package csrdc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_ACK  = 2'd2
   } conv_state_t;
endpackage

// File: rtl/csrdc_sequencer.sv
module csrdc_sequencer import csrdc_pkg::*; #(
   parameter int RATIO = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we_in,
   output logic             accept,
   output logic             busy,
   output logic             ack,
   output logic             rd_stb,
   output logic             wr_stb,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

   conv_state_t      st_q;
   logic [IDX_W-1:0] idx_q;
   logic             we_q;
   logic             last;

   assign last   = (idx_q == LAST_IDX);
   assign accept = (st_q == ST_IDLE) && req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         we_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (req) begin
                  st_q <= ST_RUN;
                  we_q <= we_in;
               end
            end
            ST_RUN: begin
               if (last) begin
                  st_q <= ST_ACK;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            ST_ACK: begin
               st_q  <= ST_IDLE;
               idx_q <= '0;
            end
            default: begin
               st_q  <= ST_IDLE;
               idx_q <= '0;
            end
         endcase
      end
   end

   assign rd_stb = (st_q == ST_RUN) && !we_q;
   assign wr_stb = (st_q == ST_RUN) && we_q;
   assign busy   = (st_q != ST_IDLE);
   assign ack    = (st_q == ST_ACK);
   assign idx    = idx_q;

   // R6: strobes never overlap
   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));
   // R2: a burst starts at chunk 0
   p_first_chunk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_stb || wr_stb) && !$past(rd_stb || wr_stb)) |-> (idx == '0));
   // R2: chunk index rises by one each strobe
   p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_stb || wr_stb) && $past(rd_stb || wr_stb)) |-> (idx == $past(idx) + IDX_W'(1)));
   // R7: acknowledge follows the last chunk strobe
   p_ack_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> ($past(rd_stb || wr_stb) && ($past(idx) == LAST_IDX)));
   // R7: acknowledge lasts one cycle
   p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   // R8: strobes only while busy
   p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> busy);
endmodule

// File: rtl/csrdc_wr_slicer.sv
module csrdc_wr_slicer #(
   parameter int CPU_W = 32,
   parameter int CSR_W = 8,
   parameter int RATIO = 4,
   parameter int IDX_W = 2
) (
   input  logic [CPU_W-1:0] word,
   input  logic [IDX_W-1:0] idx,
   output logic [CSR_W-1:0] chunk
);
   logic [CSR_W-1:0] parts [RATIO];

   for (genvar g = 0; g < RATIO; g++) begin : g_part
      assign parts[g] = word[g*CSR_W +: CSR_W];
   end

   assign chunk = parts[idx];
endmodule

// File: rtl/csrdc_rd_gather.sv
module csrdc_rd_gather #(
   parameter int CPU_W = 32,
   parameter int CSR_W = 8,
   parameter int RATIO = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic [IDX_W-1:0] idx,
   input  logic [CSR_W-1:0] csr_rdata,
   output logic [CPU_W-1:0] word
);
   logic             rd_d;
   logic [IDX_W-1:0] idx_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_d  <= 1'b0;
         idx_d <= '0;
      end else begin
         rd_d  <= rd_stb;
         idx_d <= idx;
      end
   end

   for (genvar g = 0; g < RATIO; g++) begin : g_slot
      logic [CSR_W-1:0] slot_q;
      logic             hit;
      assign hit = rd_d && (idx_d == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (hit) begin
            slot_q <= csr_rdata;
         end
      end
      // the chunk arriving this cycle bypasses its slot
      assign word[g*CSR_W +: CSR_W] = hit ? csr_rdata : slot_q;
   end
endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge import csrdc_pkg::*; #(
   parameter int CPU_W   = 32,
   parameter int CSR_W   = 8,
   parameter int WADDR_W = 8,
   localparam int RATIO  = CPU_W / CSR_W,
   localparam int IDX_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
   localparam int CSR_AW = WADDR_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [WADDR_W-1:0] cpu_addr,
   input  logic [CPU_W-1:0]   cpu_wdata,
   output logic [CPU_W-1:0]   cpu_rdata,
   output logic               cpu_ack,
   output logic               cpu_busy,
   output logic [CSR_AW-1:0]  csr_addr,
   output logic               csr_rd,
   output logic               csr_wr,
   output logic [CSR_W-1:0]   csr_wdata,
   input  logic [CSR_W-1:0]   csr_rdata
);
   if (CSR_W < 1 || CPU_W < CSR_W || (CPU_W % CSR_W) != 0) begin : g_bad_width
      $error("CPU_W must be a multiple of CSR_W");
   end
   if (RATIO < 2 || (1 << IDX_W) != RATIO) begin : g_bad_ratio
      $error("CPU_W/CSR_W must be a power of two of at least 2");
   end
   if (WADDR_W < 1) begin : g_bad_addr
      $error("WADDR_W must be positive");
   end

   logic               accept;
   logic [IDX_W-1:0]   idx;
   logic [WADDR_W-1:0] addr_q;
   logic [CPU_W-1:0]   wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= cpu_addr;
         wdata_q <= cpu_wdata;
      end
   end

   csrdc_sequencer #(.RATIO(RATIO), .IDX_W(IDX_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (cpu_req),
      .we_in  (cpu_we),
      .accept (accept),
      .busy   (cpu_busy),
      .ack    (cpu_ack),
      .rd_stb (csr_rd),
      .wr_stb (csr_wr),
      .idx    (idx)
   );

   csrdc_wr_slicer #(.CPU_W(CPU_W), .CSR_W(CSR_W), .RATIO(RATIO), .IDX_W(IDX_W)) u_slice (
      .word  (wdata_q),
      .idx   (idx),
      .chunk (csr_wdata)
   );

   csrdc_rd_gather #(.CPU_W(CPU_W), .CSR_W(CSR_W), .RATIO(RATIO), .IDX_W(IDX_W)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_stb    (csr_rd),
      .idx       (idx),
      .csr_rdata (csr_rdata),
      .word      (cpu_rdata)
   );

   assign csr_addr = {addr_q, idx};

   // R8: word address held across a burst
   p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_rd || csr_wr) && $past(csr_rd || csr_wr))
      |-> (csr_addr[CSR_AW-1:IDX_W] == $past(csr_addr[CSR_AW-1:IDX_W])));
   // R3: write data held within a chunk strobe sequence
   p_wdata_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && $past(csr_wr)) |-> $stable(wdata_q));
   // R1: idle outputs quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> (!csr_rd && !csr_wr && !cpu_ack));
endmodule

// File: tb/tb_csr_width_bridge.sv
module tb_csr_width_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int K  = 32;
   localparam int N  = 8;
   localparam int WA = 8;
   localparam logic [31:0] INC = 32'h0101_0101;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [WA-1:0] cpu_addr = '0;
   logic [K-1:0]  cpu_wdata = '0;
   logic [K-1:0]  cpu_rdata;
   logic          cpu_ack;
   logic          cpu_busy;
   logic [WA+1:0] csr_addr;
   logic          csr_rd;
   logic          csr_wr;
   logic [N-1:0]  csr_wdata;
   logic [N-1:0]  csr_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_width_bridge #(.CPU_W(K), .CSR_W(N), .WADDR_W(WA)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
      .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
   );

   // behavioural chunked register file: word 2 counter, word 5 24-bit, word 9 32-bit
   logic [31:0] ctr, r32, snap;
   logic [23:0] r24;
   logic [7:0]  stage [3];
   logic [7:0]  m_rdata;
   assign csr_rdata = m_rdata;

   function automatic logic [31:0] cur_val(input logic [7:0] w);
      case (w)
         8'd2:    return ctr;
         8'd5:    return {8'h00, r24};
         8'd9:    return r32;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rdata <= '0;
         ctr <= 32'h1122_3344;
         r24 <= 24'h0;
         r32 <= 32'h0;
         snap <= 32'h0;
         for (int i = 0; i < 3; i++) stage[i] <= 8'h0;
      end else begin
         m_rdata <= 8'h0;
         ctr <= ctr + INC;
         if (csr_rd) begin
            if (csr_addr[1:0] == 2'd0) begin
               snap <= cur_val(csr_addr[9:2]);
               m_rdata <= cur_val(csr_addr[9:2]) [7:0];
            end else begin
               m_rdata <= snap[csr_addr[1:0]*8 +: 8];
            end
         end
         if (csr_wr) begin
            if (csr_addr[1:0] != 2'd3) begin
               stage[csr_addr[1:0]] <= csr_wdata;
            end else begin
               case (csr_addr[9:2])
                  8'd2: ctr <= {csr_wdata, stage[2], stage[1], stage[0]};
                  8'd5: r24 <= {stage[2], stage[1], stage[0]};
                  8'd9: r32 <= {csr_wdata, stage[2], stage[1], stage[0]};
                  default: ;
               endcase
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   bit          watch24 = 1'b0;
   logic [23:0] watch_old = '0;

   task automatic run_access(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                             input bit scramble, output logic [31:0] rd);
      rd = '0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = wa; cpu_wdata = wd;
      for (int s = 1; s <= 5; s++) begin
         @(negedge clk);
         if (scramble) begin cpu_addr = ~wa; cpu_wdata = ~wd; end
         chk(cpu_busy, "R8 busy", {31'd0, cpu_busy}, 32'd1);
         if (s <= 4) begin
            chk(csr_rd == !we && csr_wr == we, "R6 strobe kind", {30'd0, csr_wr, csr_rd}, {30'd0, we, !we});
            chk(csr_addr == {wa, 2'(s-1)}, "R2 chunk address", {22'd0, csr_addr}, {22'd0, wa, 2'(s-1)});
            chk(!cpu_ack, "R7 early ack", {31'd0, cpu_ack}, 32'd0);
            if (we) chk(csr_wdata == wd[(s-1)*8 +: 8], "R3 chunk data", {24'd0, csr_wdata}, {24'd0, wd[(s-1)*8 +: 8]});
            if (watch24) chk(r24 == watch_old, "R5 staged only", {8'd0, r24}, {8'd0, watch_old});
         end else begin
            chk(cpu_ack && !csr_rd && !csr_wr, "R7 ack after last", {29'd0, cpu_ack, csr_wr, csr_rd}, 32'd4);
            rd = cpu_rdata;
            cpu_req = 1'b0;
         end
      end
      @(negedge clk);
      chk(!cpu_ack && !cpu_busy && !csr_rd && !csr_wr, "R7 quiet after ack",
          {28'd0, cpu_ack, cpu_busy, csr_wr, csr_rd}, 32'd0);
   endtask

   task automatic t_reset;
      chk(!csr_rd && !csr_wr && !cpu_ack && !cpu_busy, "R1 reset state",
          {28'd0, cpu_ack, cpu_busy, csr_wr, csr_rd}, 32'd0);
      repeat (3) @(negedge clk);
      chk(!csr_rd && !csr_wr && !cpu_ack && !cpu_busy, "R1 idle without request",
          {28'd0, cpu_ack, cpu_busy, csr_wr, csr_rd}, 32'd0);
   endtask

   task automatic t_plain_roundtrip;
      logic [31:0] rd;
      run_access(1'b1, 8'd9, 32'hA1B2_C3D4, 1'b0, rd);
      chk(r32 == 32'hA1B2_C3D4, "R5 full write committed", r32, 32'hA1B2_C3D4);
      run_access(1'b0, 8'd9, 32'h0, 1'b0, rd);
      chk(rd == 32'hA1B2_C3D4, "R4 read assembly", rd, 32'hA1B2_C3D4);
   endtask

   task automatic t_commit_narrow;
      logic [31:0] rd;
      watch_old = r24;
      watch24 = 1'b1;
      run_access(1'b1, 8'd5, 32'hEE65_4321, 1'b0, rd);
      watch24 = 1'b0;
      chk(r24 == 24'h654321, "R5 commit on fourth write", {8'd0, r24}, 32'h0065_4321);
      run_access(1'b0, 8'd5, 32'h0, 1'b0, rd);
      chk(rd == 32'h0065_4321, "R4 narrow register top chunk zero", rd, 32'h0065_4321);
   endtask

   task automatic t_snapshot;
      logic [31:0] rd;
      run_access(1'b0, 8'd2, 32'h0, 1'b0, rd);
      chk(rd == snap, "R4 snapshot of changing register", rd, snap);
      chk(rd != ctr, "R4 counter moved on", rd, ctr);
   endtask

   task automatic t_unmapped;
      logic [31:0] rd;
      run_access(1'b0, 8'h77, 32'h0, 1'b0, rd);
      chk(rd == 32'h0, "R4 unmapped reads zero", rd, 32'h0);
   endtask

   task automatic t_scramble;
      logic [31:0] rd;
      run_access(1'b1, 8'd9, 32'h5A5A_0FF0, 1'b1, rd);
      chk(r32 == 32'h5A5A_0FF0, "R8 fields captured at acceptance", r32, 32'h5A5A_0FF0);
      run_access(1'b0, 8'd9, 32'h0, 1'b1, rd);
      chk(rd == 32'h5A5A_0FF0, "R8 read after scramble", rd, 32'h5A5A_0FF0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_roundtrip();
      t_commit_narrow();
      t_snapshot();
      t_unmapped();
      t_scramble();
      t_snapshot();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule